// File: doc/BRIEF.md
# Bus-Side Access Controller for a Memory-Exposed Compute Cluster

This block is the slave-side control logic that sits between an AHB bus and an accelerator whose instruction and data memories are reachable from the bus. It watches the address phase of each transfer (select, transfer type, direction, bus ready) and a pair of legality checks supplied by its neighbours. It also watches a busy flag from the compute cluster. From these it drives the slave ready and response lines, strobes the memory read and write enables, and tells an external address generator when to load a fresh start address and when to advance to the next beat.

A write burst is served at one beat per cycle with no wait states. A read stalls the bus for a fixed latency (two cycles by default) before the first data beat, and then streams one beat per cycle. A master may pause a burst with BUSY cycles and resume it. An illegal access is answered with a two-cycle ERROR response: out-of-range addresses, and accesses that arrive without a proper grant. While the cluster is computing, any access is turned away with a two-cycle RETRY and does not reach the memories.

Top module: `ahb_acc_ctl`

## Requirements
- R1: After reset the controller is idle: ready out is 1, the response is OKAY (code 00), and the memory write, memory read, load and advance outputs are all 0.
- R2: In the idle state, a transfer of type IDLE (00) or BUSY (01), or an unselected cycle, gets a zero-wait OKAY response, raises no memory enable and no load, and leaves the controller idle.
- R3: A selected NONSEQ (10) write with a valid address and grant raises load in its address-phase cycle. In the next cycle it raises the memory write enable with ready out 1 and OKAY.
- R4: A selected NONSEQ read with a valid address and grant raises load in its address-phase cycle. Ready out is then 0 with OKAY for RD_LAT cycles, with the memory read enable high in the first of them. After that, ready out returns to 1 for the first data beat.
- R5: During a burst, a selected SEQ (11) transfer with a valid address raises advance in its address-phase cycle, and the burst continues at one beat per cycle with ready out 1. A write beat raises the memory write enable in its data phase. A read continuation raises the memory read enable together with advance.
- R6: A BUSY transfer during a burst pauses it. The following cycle has ready out 1, OKAY and no memory write. A later SEQ resumes the burst with advance raised.
- R7: A NONSEQ with an invalid address or missing grant, or a SEQ with an invalid address, produces no load or advance. It is followed by a response of ERROR (01) with ready out 0, then ERROR with ready out 1, then the idle state.
- R8: The compute state is entered only from idle, when the cluster busy flag is high and no NONSEQ is accepted. A busy flag seen while a burst is active has no effect on that burst or on the following idle state.
- R9: Any selected NONSEQ or SEQ transfer during the compute state is answered with RETRY (10), ready out 0, then RETRY with ready out 1. It raises no memory enable, load or advance.
- R10: When the busy flag is low in the compute state and no retry is in progress, the controller returns to idle, and the next NONSEQ is served normally.
- R11: In a burst, an IDLE transfer or an unselected cycle ends the burst and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel_i | input | 1 | Slave select from the address decoder |
| htrans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite_i | input | 1 | 1 for write, 0 for read |
| hready_i | input | 1 | Bus ready; the address phase is taken only when high |
| addr_ok_i | input | 1 | Address lies within the memory depth |
| grant_ok_i | input | 1 | Master holds a proper grant for this access |
| clu_busy_i | input | 1 | Compute cluster is working |
| hreadyout_o | output | 1 | Slave ready out |
| hresp_o | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY |
| mem_wr_o | output | 1 | Memory write enable (data phase of a write beat) |
| mem_rd_o | output | 1 | Memory read enable |
| agu_load_o | output | 1 | Address generator loads the start address |
| agu_step_o | output | 1 | Address generator advances one beat |

## Verification
A state register that lands in the wrong place shows at the ports within one cycle. A stray stall appears as ready out low where a zero-wait beat was due. A missed burst appears as a data phase without its write enable. A wrong exit from the compute state makes the next NONSEQ raise load when it should have been retried. An error or retry response cut short, or held too long, shows as a response code that changes one cycle early or late. Read-latency faults show as a first data beat that arrives a cycle early or late. The bench drives each state's exits one by one and compares every output in every cycle, so a fault is caught in the cycle it first appears.

// File: rtl/ahb_acc_pkg.sv
package ahb_acc_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } tr_e;

  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERR   = 2'b01,
    RS_RETRY = 2'b10
  } rs_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACC    = 3'd1,
    ST_WORK   = 3'd2,
    ST_RDWAIT = 3'd3,
    ST_HOLD   = 3'd4,
    ST_ERR    = 3'd5
  } st_e;

  // Classified address-phase event
  typedef struct packed {
    logic start_ok;
    logic start_bad;
    logic cont_ok;
    logic cont_bad;
    logic pause;
  } ap_t;

  // An address phase is taken when selected, bus ready and type is NONSEQ/SEQ
  function automatic logic phase_live(input logic sel, input logic rdy, input logic [1:0] tr);
    return sel & rdy & tr[1];
  endfunction

  // Counter width able to hold the larger of the read latency and 2
  function automatic int cnt_bits(input int lat);
    return (lat > 3) ? $clog2(lat + 1) : 2;
  endfunction

endpackage

// File: rtl/ahb_acc_apdec.sv
module ahb_acc_apdec
  import ahb_acc_pkg::*;
(
  input  logic       sel_i,
  input  logic       rdy_i,
  input  logic [1:0] trans_i,
  input  logic       addr_ok_i,
  input  logic       grant_ok_i,
  output ap_t        ev_o
);
  logic live, legal;

  always_comb begin
    live  = phase_live(sel_i, rdy_i, trans_i);
    legal = addr_ok_i & grant_ok_i;
    ev_o.start_ok  = live & (trans_i == TR_NSEQ) & legal;
    ev_o.start_bad = live & (trans_i == TR_NSEQ) & ~legal;
    ev_o.cont_ok   = live & (trans_i == TR_SEQ) & addr_ok_i;
    ev_o.cont_bad  = live & (trans_i == TR_SEQ) & ~addr_ok_i;
    ev_o.pause     = sel_i & rdy_i & (trans_i == TR_BUSY);
  end
endmodule

// File: rtl/ahb_acc_fsm.sv
module ahb_acc_fsm
  import ahb_acc_pkg::*;
#(
  parameter int RD_LAT = 2,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ap_t           ev_i,
  input  logic          write_i,
  input  logic          busy_i,
  output st_e           st_o,
  output logic [CW-1:0] cnt_o,
  output logic          is_wr_o,
  output logic          load_o,
  output logic          step_o
);
  localparam logic [CW-1:0] LAT_LAST = CW'(RD_LAT - 1);
  localparam logic [CW-1:0] PH_NONE  = CW'(0);
  localparam logic [CW-1:0] PH_ONE   = CW'(1);
  localparam logic [CW-1:0] PH_TWO   = CW'(2);

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic          in_burst, any_access;

  always_comb begin
    in_burst   = (st_q == ST_ACC) || (st_q == ST_HOLD);
    any_access = ev_i.start_ok | ev_i.start_bad | ev_i.cont_ok | ev_i.cont_bad;
    load_o     = ev_i.start_ok & (in_burst || st_q == ST_IDLE);
    step_o     = ev_i.cont_ok & in_burst;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    wr_d  = wr_q;
    unique case (st_q)
      ST_IDLE, ST_ACC, ST_HOLD: begin
        if (ev_i.start_bad || (in_burst && ev_i.cont_bad)) begin
          st_d = ST_ERR;
        end else if (ev_i.start_ok) begin
          wr_d = write_i;
          st_d = write_i ? ST_ACC : ST_RDWAIT;
        end else if (in_burst) begin
          if (ev_i.cont_ok)    st_d = ST_ACC;
          else if (ev_i.pause) st_d = ST_HOLD;
          else                 st_d = ST_IDLE;
        end else if (busy_i) begin
          st_d = ST_WORK;
        end
        cnt_d = PH_NONE;
      end
      ST_RDWAIT: begin
        if (cnt_q == LAT_LAST) begin
          st_d  = ST_ACC;
          cnt_d = PH_NONE;
        end else begin
          cnt_d = cnt_q + PH_ONE;
        end
      end
      ST_ERR: begin
        if (cnt_q == PH_ONE) begin
          st_d  = ST_IDLE;
          cnt_d = PH_NONE;
        end else begin
          cnt_d = PH_ONE;
        end
      end
      ST_WORK: begin
        // cnt: 0 = no retry, 1 = retry stall cycle, 2 = retry release cycle
        if (cnt_q == PH_ONE) begin
          cnt_d = PH_TWO;
        end else if (any_access) begin
          cnt_d = PH_ONE;
        end else if (cnt_q == PH_TWO) begin
          cnt_d = PH_NONE;
        end else if (!busy_i) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = PH_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= PH_NONE;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
    end
  end

  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign is_wr_o = wr_q;
endmodule

// File: rtl/ahb_acc_resp.sv
module ahb_acc_resp
  import ahb_acc_pkg::*;
#(
  parameter int CW = 2
) (
  input  st_e           st_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          is_wr_i,
  input  logic          step_i,
  output logic          ready_o,
  output logic [1:0]    resp_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o
);
  logic err_stall, rty_stall, rty_any;

  always_comb begin
    err_stall = (st_i == ST_ERR)  && (cnt_i == CW'(0));
    rty_stall = (st_i == ST_WORK) && (cnt_i == CW'(1));
    rty_any   = (st_i == ST_WORK) && (cnt_i != CW'(0));
    ready_o   = !((st_i == ST_RDWAIT) || err_stall || rty_stall);
    if (st_i == ST_ERR) resp_o = RS_ERR;
    else if (rty_any)   resp_o = RS_RETRY;
    else                resp_o = RS_OKAY;
    mem_wr_o  = (st_i == ST_ACC) && is_wr_i;
    mem_rd_o  = ((st_i == ST_RDWAIT) && (cnt_i == CW'(0))) || (step_i && !is_wr_i);
  end
endmodule

// File: rtl/ahb_acc_ctl.sv
module ahb_acc_ctl
  import ahb_acc_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsel_i,
  input  logic [1:0] htrans_i,
  input  logic       hwrite_i,
  input  logic       hready_i,
  input  logic       addr_ok_i,
  input  logic       grant_ok_i,
  input  logic       clu_busy_i,
  output logic       hreadyout_o,
  output logic [1:0] hresp_o,
  output logic       mem_wr_o,
  output logic       mem_rd_o,
  output logic       agu_load_o,
  output logic       agu_step_o
);
  localparam int CW = cnt_bits(RD_LAT);

  ap_t           ev_w;
  st_e           st_w;
  logic [CW-1:0] cnt_w;
  logic          is_wr_w;
  logic          load_w, step_w;

  ahb_acc_apdec u_dec (
    .sel_i      (hsel_i),
    .rdy_i      (hready_i),
    .trans_i    (htrans_i),
    .addr_ok_i  (addr_ok_i),
    .grant_ok_i (grant_ok_i),
    .ev_o       (ev_w)
  );

  ahb_acc_fsm #(.RD_LAT(RD_LAT), .CW(CW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev_w),
    .write_i (hwrite_i),
    .busy_i  (clu_busy_i),
    .st_o    (st_w),
    .cnt_o   (cnt_w),
    .is_wr_o (is_wr_w),
    .load_o  (load_w),
    .step_o  (step_w)
  );

  ahb_acc_resp #(.CW(CW)) u_resp (
    .st_i     (st_w),
    .cnt_i    (cnt_w),
    .is_wr_i  (is_wr_w),
    .step_i   (step_w),
    .ready_o  (hreadyout_o),
    .resp_o   (hresp_o),
    .mem_wr_o (mem_wr_o),
    .mem_rd_o (mem_rd_o)
  );

  assign agu_load_o = load_w;
  assign agu_step_o = step_w;
endmodule

// File: rtl/ahb_acc_ctl_chk.sv
module ahb_acc_ctl_chk
  import ahb_acc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input st_e        st,
  input logic       hreadyout_o,
  input logic [1:0] hresp_o,
  input logic       mem_wr_o,
  input logic       mem_rd_o,
  input logic       agu_load_o,
  input logic       agu_step_o
);
  a_r1_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> hreadyout_o && hresp_o == RS_OKAY && !mem_wr_o);

  a_r4_rdwait_stall: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RDWAIT |-> !hreadyout_o && !mem_wr_o && hresp_o == RS_OKAY);

  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HOLD |-> hreadyout_o && !mem_wr_o && hresp_o == RS_OKAY);

  a_r7_err_enter_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERR && $past(st) != ST_ERR) |-> !hreadyout_o);

  a_r7_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp_o == RS_ERR && !hreadyout_o) |=> (hresp_o == RS_ERR && hreadyout_o));

  a_r8_work_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WORK && $past(st) != ST_WORK) |-> $past(st) == ST_IDLE);

  a_r9_retry_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp_o == RS_RETRY && !hreadyout_o) |=> (hresp_o == RS_RETRY && hreadyout_o));

  a_r9_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hresp_o == RS_RETRY |-> !mem_wr_o && !mem_rd_o && !agu_load_o && !agu_step_o);

  a_r5_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o) && !(agu_load_o && agu_step_o));
endmodule

bind ahb_acc_ctl ahb_acc_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (st_w),
  .hreadyout_o (hreadyout_o),
  .hresp_o     (hresp_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rd_o    (mem_rd_o),
  .agu_load_o  (agu_load_o),
  .agu_step_o  (agu_step_o)
);

// File: tb/sim_ahb_acc_ctl.sv
module sim_ahb_acc_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsel = 1'b0, hwrite = 1'b0, aok = 1'b1, gok = 1'b1, busy = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic rdy, wr, rd, ld, stp;
  logic [1:0] resp;

  always #2.5 clk = ~clk;

  ahb_acc_ctl #(.RD_LAT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hsel_i(hsel), .htrans_i(htrans), .hwrite_i(hwrite),
    .hready_i(rdy), .addr_ok_i(aok), .grant_ok_i(gok), .clu_busy_i(busy),
    .hreadyout_o(rdy), .hresp_o(resp), .mem_wr_o(wr), .mem_rd_o(rd),
    .agu_load_o(ld), .agu_step_o(stp)
  );

  typedef struct packed {
    logic       rdy;
    logic [1:0] resp;
    logic       wr;
    logic       rd;
    logic       ld;
    logic       stp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Driver: apply one cycle of inputs and push the outputs expected in that cycle
  task automatic drv(input logic s, input logic [1:0] tr, input logic w, input logic a,
                     input logic g, input logic b, input exp_t e, input string tag);
    @(negedge clk);
    hsel = s; htrans = tr; hwrite = w; aok = a; gok = g; busy = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  function automatic exp_t mk(input logic r, input logic [1:0] rs, input logic w,
                              input logic d, input logic l, input logic s);
    exp_t e;
    e.rdy = r; e.resp = rs; e.wr = w; e.rd = d; e.ld = l; e.stp = s;
    return e;
  endfunction

  // Monitor: compare outputs 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = mk(rdy, resp, wr, rd, ld, stp);
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got rdy=%b resp=%b wr=%b rd=%b ld=%b stp=%b, expected rdy=%b resp=%b wr=%b rd=%b ld=%b stp=%b",
                   t, a.rdy, a.resp, a.wr, a.rd, a.ld, a.stp, e.rdy, e.resp, e.wr, e.rd, e.ld, e.stp);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [1:0] I = 2'b00, B = 2'b01, N = 2'b10, S = 2'b11;
  localparam logic [1:0] OK = 2'b00, ER = 2'b01, RT = 2'b10;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R1 reset idle");
    // R2: IDLE and BUSY types ignored in idle
    drv(1, B, 1, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R2 busy type in idle");
    drv(1, I, 1, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R2 idle type in idle");
    drv(1, S, 1, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R2 stays idle");
    // R3/R5/R6/R11: write burst with a pause
    drv(1, N, 1, 1, 1, 0, mk(1, OK, 0, 0, 1, 0), "R3 write load");
    drv(1, S, 1, 1, 1, 0, mk(1, OK, 1, 0, 0, 1), "R3 R5 write beat and advance");
    drv(1, B, 1, 1, 1, 0, mk(1, OK, 1, 0, 0, 0), "R5 second write beat");
    drv(1, B, 1, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R6 paused, no write");
    drv(1, S, 1, 1, 1, 0, mk(1, OK, 0, 0, 0, 1), "R6 resume advance");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 1, 0, 0, 0), "R6 resumed beat written");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R11 burst ended to idle");
    // R4/R5: read burst
    drv(1, N, 0, 1, 1, 0, mk(1, OK, 0, 0, 1, 0), "R4 read load");
    drv(1, N, 0, 1, 1, 0, mk(0, OK, 0, 1, 0, 0), "R4 latency cycle 1");
    drv(1, N, 0, 1, 1, 0, mk(0, OK, 0, 0, 0, 0), "R4 latency cycle 2");
    drv(1, S, 0, 1, 1, 0, mk(1, OK, 0, 1, 0, 1), "R4 R5 first read beat");
    drv(1, S, 0, 1, 1, 0, mk(1, OK, 0, 1, 0, 1), "R5 streaming read beat");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R11 read burst end");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R11 idle after read");
    // R7: bad address on NONSEQ
    drv(1, N, 1, 0, 1, 0, mk(1, OK, 0, 0, 0, 0), "R7 bad address no load");
    drv(0, I, 0, 1, 1, 0, mk(0, ER, 0, 0, 0, 0), "R7 error stall");
    drv(0, I, 0, 1, 1, 0, mk(1, ER, 0, 0, 0, 0), "R7 error release");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R7 back to idle");
    // R7: missing grant on read
    drv(1, N, 0, 1, 0, 0, mk(1, OK, 0, 0, 0, 0), "R7 no grant no load");
    drv(0, I, 0, 1, 1, 0, mk(0, ER, 0, 0, 0, 0), "R7 grant error stall");
    drv(0, I, 0, 1, 1, 0, mk(1, ER, 0, 0, 0, 0), "R7 grant error release");
    // R7: bad address on SEQ inside a write burst
    drv(1, N, 1, 1, 1, 0, mk(1, OK, 0, 0, 1, 0), "R7 burst start");
    drv(1, S, 1, 0, 1, 0, mk(1, OK, 1, 0, 0, 0), "R7 bad seq no advance");
    drv(0, I, 0, 1, 1, 0, mk(0, ER, 0, 0, 0, 0), "R7 seq error stall");
    drv(0, I, 0, 1, 1, 0, mk(1, ER, 0, 0, 0, 0), "R7 seq error release");
    // R8/R9/R10: compute state, retry, exit
    drv(0, I, 0, 1, 1, 1, mk(1, OK, 0, 0, 0, 0), "R8 idle sees busy");
    drv(0, I, 0, 1, 1, 1, mk(1, OK, 0, 0, 0, 0), "R8 in compute, quiet");
    drv(1, N, 1, 1, 1, 1, mk(1, OK, 0, 0, 0, 0), "R9 access in compute no load");
    drv(0, I, 0, 1, 1, 1, mk(0, RT, 0, 0, 0, 0), "R9 retry stall");
    drv(0, I, 0, 1, 1, 1, mk(1, RT, 0, 0, 0, 0), "R9 retry release");
    drv(1, S, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R9 seq in compute no advance");
    drv(0, I, 0, 1, 1, 0, mk(0, RT, 0, 0, 0, 0), "R9 second retry stall");
    drv(0, I, 0, 1, 1, 0, mk(1, RT, 0, 0, 0, 0), "R9 second retry release");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R10 busy low leaves compute");
    drv(1, N, 1, 1, 1, 0, mk(1, OK, 0, 0, 1, 0), "R10 next access served");
    // R8: busy during a burst is ignored
    drv(1, S, 1, 1, 1, 1, mk(1, OK, 1, 0, 0, 1), "R8 busy in burst ignored");
    drv(0, I, 0, 1, 1, 1, mk(1, OK, 1, 0, 0, 0), "R8 burst continues");
    drv(1, N, 1, 1, 1, 0, mk(1, OK, 0, 0, 1, 0), "R8 no compute after burst");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 1, 0, 0, 0), "R8 write served");
    drv(0, I, 0, 1, 1, 0, mk(1, OK, 0, 0, 0, 0), "R11 final idle");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule